// File: doc/BRIEF.md
# Tag-Matching Reservation Station Bank

This block is the waiting room in front of one functional unit of an out-of-order core. At issue time it takes an operation, two source operands and the reorder-buffer slot number of the result. Each source operand arrives either as a value or, if its producer has not finished yet, as the reorder-buffer number of that producer. Entries that are still waiting watch the common result bus. When a broadcast carries the tag an entry is waiting for, the entry copies the value.

An entry whose operands are complete can be dispatched. When several entries can go, the oldest one by allocation order goes first. The simple execution unit registers its result and presents it with the entry's reorder-buffer tag. That result leaves the bank on the same clock edge that frees the station. Store entries only compute an address, so they can go as soon as the base operand is present. A flush empties the whole bank in one cycle.

Top module: `rs_bank`

## Requirements
- R1: `iss_ready_o` is high only when at least one station is free, `rob_free_i` is high and `flush_i` is low. An operation is taken on a rising edge where `iss_valid_i` and `iss_ready_o` are both high.
- R2: A source marked ready at issue is stored as the value given. Results use the op encoding 0 add, 1 subtract (src1 - src2), 2 and, 3 or, 4 xor.
- R3: A waiting source captures `cdb_data_i` on the first edge where `cdb_valid_i` is high and `cdb_tag_i` equals its tag. A broadcast with any other tag leaves it waiting.
- R4: A broadcast in the same cycle as issue whose tag matches a not-ready source of that issue fills the source in the new entry.
- R5: A non-store entry is not dispatched while either source is still waiting.
- R6: A store entry (op code 5) is dispatched once src1 is present, even when src2 still waits. Its result is src1 + `iss_imm_i`.
- R7: An entry dispatched in cycle c appears on `res_valid_o`, `res_tag_o` and `res_data_o` after the edge that ends cycle c. Its tag is the destination tag given at issue.
- R8: A station is free from the edge on which its result is presented, so `iss_ready_o` can rise in that same cycle.
- R9: When several entries are ready in the same cycle, the one allocated earliest is dispatched first, whatever station it occupies.
- R10: A flush empties every station and cancels the pending result in one cycle. Flushed entries never produce a result.
- R11: At most one entry is dispatched per cycle. Remaining ready entries follow on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all entries and the pending result |
| rob_free_i | input | 1 | Reorder buffer has a free slot |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | Issue can be accepted |
| iss_op_i | input | 3 | Operation code |
| iss_src1_rdy_i | input | 1 | Source 1 given as a value |
| iss_src1_val_i | input | DATA_W | Source 1 value |
| iss_src1_tag_i | input | TAG_W | Source 1 producer tag |
| iss_src2_rdy_i | input | 1 | Source 2 given as a value |
| iss_src2_val_i | input | DATA_W | Source 2 value |
| iss_src2_tag_i | input | TAG_W | Source 2 producer tag |
| iss_imm_i | input | DATA_W | Store address offset |
| iss_dst_tag_i | input | TAG_W | Reorder-buffer slot of the result |
| cdb_valid_i | input | 1 | Result bus broadcast valid |
| cdb_tag_i | input | TAG_W | Broadcast tag |
| cdb_data_i | input | DATA_W | Broadcast value |
| res_valid_o | output | 1 | Result valid |
| res_tag_o | output | TAG_W | Result tag |
| res_data_o | output | DATA_W | Result value |

## Verification
When every source is given as a value at issue, the result appears two edges after issue: one edge to allocate the entry and one to register the result. When the last missing source comes off the bus, the result appears two edges after that broadcast: one edge to capture the value and one to register the result. The station is free at the second of those edges, and a flush takes effect at the next edge.

The bench drives inputs and samples outputs one time unit after each rising edge. It checks that no result appears at the intermediate edge and that the result does appear at the predicted one. It then checks `iss_ready_o` in that same cycle. For the ordering cases, the bench places the older entry in the higher-numbered station, so index order and age order give different answers.

// File: rtl/rs_bank_pkg.sv
package rs_bank_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_STA = 3'd5
  } rs_op_e;

  function automatic logic op_needs_b(input rs_op_e op);
    return op != OP_STA;
  endfunction

endpackage

// File: rtl/rs_opnd.sv
// One source operand slot: load at allocation, snoop the result bus after.
module rs_opnd #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              live_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              cdb_v_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o
);

  logic              rdy_q, rdy_n;
  logic [DATA_W-1:0] val_q, val_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic              fwd_hit, snoop_hit, en;

  always_comb begin
    fwd_hit   = cdb_v_i && !rdy_i && (cdb_tag_i == tag_i);
    snoop_hit = live_i && !rdy_q && cdb_v_i && (cdb_tag_i == tag_q);
    en        = load_i || snoop_hit;
    rdy_n     = rdy_q;
    val_n     = val_q;
    tag_n     = tag_q;
    if (load_i) begin
      rdy_n = rdy_i || fwd_hit;
      val_n = rdy_i ? val_i : cdb_data_i;
      tag_n = tag_i;
    end else if (snoop_hit) begin
      rdy_n = 1'b1;
      val_n = cdb_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      val_q <= '0;
      tag_q <= '0;
    end else if (en) begin
      rdy_q <= rdy_n;
      val_q <= val_n;
      tag_q <= tag_n;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  // R3
  snoop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !load_i && !rdy_q && cdb_v_i && cdb_tag_i == tag_q)
      |=> (rdy_q && val_q == $past(cdb_data_i)));

  // R3
  tag_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !load_i && !rdy_q && !(cdb_v_i && cdb_tag_i == tag_q))
      |=> !rdy_q);

endmodule

// File: rtl/rs_slot.sv
// One reservation station: op, two operands, destination tag and age rank.
module rs_slot
  import rs_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int AGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  rs_op_e            op_i,
  input  logic              a_rdy_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic              b_rdy_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [TAG_W-1:0]  dst_i,
  input  logic [AGE_W-1:0]  age_i,
  input  logic              release_i,
  input  logic              age_dec_i,
  input  logic              cdb_v_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              valid_o,
  output logic              ready_o,
  output rs_op_e            op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] imm_o,
  output logic [TAG_W-1:0]  dst_o,
  output logic [AGE_W-1:0]  age_o
);

  logic              vld_q, vld_n;
  rs_op_e            op_q;
  logic [DATA_W-1:0] imm_q;
  logic [TAG_W-1:0]  dst_q;
  logic [AGE_W-1:0]  age_q, age_n;
  logic              age_en;
  logic              a_rdy, b_rdy;

  rs_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (alloc_i),
    .live_i     (vld_q),
    .rdy_i      (a_rdy_i),
    .val_i      (a_val_i),
    .tag_i      (a_tag_i),
    .cdb_v_i    (cdb_v_i),
    .cdb_tag_i  (cdb_tag_i),
    .cdb_data_i (cdb_data_i),
    .rdy_o      (a_rdy),
    .val_o      (a_o)
  );

  rs_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_b (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (alloc_i),
    .live_i     (vld_q),
    .rdy_i      (b_rdy_i),
    .val_i      (b_val_i),
    .tag_i      (b_tag_i),
    .cdb_v_i    (cdb_v_i),
    .cdb_tag_i  (cdb_tag_i),
    .cdb_data_i (cdb_data_i),
    .rdy_o      (b_rdy),
    .val_o      (b_o)
  );

  always_comb begin
    vld_n = vld_q;
    if (flush_i)        vld_n = 1'b0;
    else if (alloc_i)   vld_n = 1'b1;
    else if (release_i) vld_n = 1'b0;
    age_en = alloc_i || (age_dec_i && vld_q);
    age_n  = alloc_i ? age_i : age_q - AGE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_ADD;
      imm_q <= '0;
      dst_q <= '0;
    end else if (alloc_i) begin
      op_q  <= op_i;
      imm_q <= imm_i;
      dst_q <= dst_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (age_en) age_q <= age_n;
  end

  assign ready_o = vld_q && a_rdy && (b_rdy || !op_needs_b(op_q));
  assign valid_o = vld_q;
  assign op_o    = op_q;
  assign imm_o   = imm_q;
  assign dst_o   = dst_q;
  assign age_o   = age_q;

  // R5 R6
  dispatch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> (vld_q && a_rdy && (b_rdy || op_q == OP_STA)));

  // R9
  age_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_dec_i && vld_q) |-> (age_q != '0));

  // R1
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !vld_q);

endmodule

// File: rtl/rs_pick.sv
// Oldest-ready grant and lowest free station search.
module rs_pick #(
  parameter int N_ENT = 4,
  parameter int AGE_W = 2,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] valid_i,
  input  logic [N_ENT-1:0] ready_i,
  input  logic [AGE_W-1:0] age_i [N_ENT],
  output logic [N_ENT-1:0] grant_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             grant_any_o,
  output logic [N_ENT-1:0] free_o,
  output logic             free_any_o
);

  logic [AGE_W-1:0] best_age;

  always_comb begin
    grant_o     = '0;
    grant_idx_o = '0;
    grant_any_o = 1'b0;
    best_age    = '1;
    for (int i = 0; i < N_ENT; i++) begin
      if (ready_i[i] && (!grant_any_o || age_i[i] < best_age)) begin
        grant_any_o = 1'b1;
        best_age    = age_i[i];
        grant_idx_o = IDX_W'(i);
      end
    end
    if (grant_any_o) grant_o[grant_idx_o] = 1'b1;
  end

  always_comb begin
    free_o     = '0;
    free_any_o = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!valid_i[i] && !free_any_o) begin
        free_o[i]  = 1'b1;
        free_any_o = 1'b1;
      end
    end
  end

  // R11
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & ~ready_i) == '0));

  // R1
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(free_o) && ((free_o & valid_i) == '0));

endmodule

// File: rtl/rs_exec.sv
// Single-cycle execution unit with registered result.
module rs_exec
  import rs_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              go_i,
  input  rs_op_e            op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              res_v_o,
  output logic [TAG_W-1:0]  res_tag_o,
  output logic [DATA_W-1:0] res_data_o
);

  logic              v_q, v_n;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q, alu;
  logic              load_en;

  always_comb begin
    unique case (op_i)
      OP_SUB:  alu = a_i - b_i;
      OP_AND:  alu = a_i & b_i;
      OP_OR:   alu = a_i | b_i;
      OP_XOR:  alu = a_i ^ b_i;
      OP_STA:  alu = a_i + imm_i;
      default: alu = a_i + b_i;
    endcase
    v_n     = go_i && !flush_i;
    load_en = v_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      data_q <= '0;
    end else if (load_en) begin
      tag_q  <= tag_i;
      data_q <= alu;
    end
  end

  assign res_v_o    = v_q;
  assign res_tag_o  = tag_q;
  assign res_data_o = data_q;

  // R7
  res_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> $past(go_i && !flush_i));

  // R10
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !v_q);

endmodule

// File: rtl/rs_bank.sv
// Reservation station bank for one functional unit.
module rs_bank
  import rs_bank_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              rob_free_i,
  input  logic              iss_valid_i,
  output logic              iss_ready_o,
  input  logic [2:0]        iss_op_i,
  input  logic              iss_src1_rdy_i,
  input  logic [DATA_W-1:0] iss_src1_val_i,
  input  logic [TAG_W-1:0]  iss_src1_tag_i,
  input  logic              iss_src2_rdy_i,
  input  logic [DATA_W-1:0] iss_src2_val_i,
  input  logic [TAG_W-1:0]  iss_src2_tag_i,
  input  logic [DATA_W-1:0] iss_imm_i,
  input  logic [TAG_W-1:0]  iss_dst_tag_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              res_valid_o,
  output logic [TAG_W-1:0]  res_tag_o,
  output logic [DATA_W-1:0] res_data_o
);

  localparam int AGE_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int IDX_W = AGE_W;

  logic [N_ENT-1:0]  slot_vld, slot_rdy, grant, free, alloc, age_dec;
  logic [IDX_W-1:0]  grant_idx;
  logic              grant_any, free_any, accept, disp_fire;
  logic [AGE_W-1:0]  slot_age [N_ENT];
  rs_op_e            slot_op  [N_ENT];
  logic [DATA_W-1:0] slot_a   [N_ENT];
  logic [DATA_W-1:0] slot_b   [N_ENT];
  logic [DATA_W-1:0] slot_imm [N_ENT];
  logic [TAG_W-1:0]  slot_dst [N_ENT];
  logic [AGE_W-1:0]  new_age;
  rs_op_e            d_op;
  logic [DATA_W-1:0] d_a, d_b, d_imm;
  logic [TAG_W-1:0]  d_dst;

  assign iss_ready_o = free_any && rob_free_i && !flush_i;
  assign accept      = iss_valid_i && iss_ready_o;
  assign disp_fire   = grant_any && !flush_i;
  assign alloc       = accept ? free : '0;

  // Rank of a new entry: number of entries that stay after this edge.
  always_comb begin
    new_age = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (slot_vld[i] && !(disp_fire && grant[i])) new_age = new_age + AGE_W'(1);
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      age_dec[i] = disp_fire && slot_vld[i] && (slot_age[i] > slot_age[grant_idx]);
    end
  end

  always_comb begin
    d_op  = OP_ADD;
    d_a   = '0;
    d_b   = '0;
    d_imm = '0;
    d_dst = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant[i]) begin
        d_op  = slot_op[i];
        d_a   = slot_a[i];
        d_b   = slot_b[i];
        d_imm = slot_imm[i];
        d_dst = slot_dst[i];
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .alloc_i    (alloc[g]),
      .op_i       (rs_op_e'(iss_op_i)),
      .a_rdy_i    (iss_src1_rdy_i),
      .a_val_i    (iss_src1_val_i),
      .a_tag_i    (iss_src1_tag_i),
      .b_rdy_i    (iss_src2_rdy_i),
      .b_val_i    (iss_src2_val_i),
      .b_tag_i    (iss_src2_tag_i),
      .imm_i      (iss_imm_i),
      .dst_i      (iss_dst_tag_i),
      .age_i      (new_age),
      .release_i  (disp_fire && grant[g]),
      .age_dec_i  (age_dec[g]),
      .cdb_v_i    (cdb_valid_i),
      .cdb_tag_i  (cdb_tag_i),
      .cdb_data_i (cdb_data_i),
      .valid_o    (slot_vld[g]),
      .ready_o    (slot_rdy[g]),
      .op_o       (slot_op[g]),
      .a_o        (slot_a[g]),
      .b_o        (slot_b[g]),
      .imm_o      (slot_imm[g]),
      .dst_o      (slot_dst[g]),
      .age_o      (slot_age[g])
    );
  end

  rs_pick #(.N_ENT(N_ENT), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (slot_vld),
    .ready_i     (slot_rdy),
    .age_i       (slot_age),
    .grant_o     (grant),
    .grant_idx_o (grant_idx),
    .grant_any_o (grant_any),
    .free_o      (free),
    .free_any_o  (free_any)
  );

  rs_exec #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .go_i       (disp_fire),
    .op_i       (d_op),
    .a_i        (d_a),
    .b_i        (d_b),
    .imm_i      (d_imm),
    .tag_i      (d_dst),
    .res_v_o    (res_valid_o),
    .res_tag_o  (res_tag_o),
    .res_data_o (res_data_o)
  );

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (slot_vld == '0));

  // R1
  issue_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rob_free_i |=> ($countones(slot_vld) <= $past($countones(slot_vld))));

  // R8
  free_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (res_valid_o && !slot_vld[$past(grant_idx)]));

endmodule

// File: tb/rs_bank_bench.sv
`timescale 1ns/1ps
module rs_bank_bench;

  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;
  localparam int N_ENT  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flush_i, rob_free_i, iss_valid_i, iss_ready_o;
  logic [2:0]        iss_op_i;
  logic              iss_src1_rdy_i, iss_src2_rdy_i;
  logic [DATA_W-1:0] iss_src1_val_i, iss_src2_val_i, iss_imm_i;
  logic [TAG_W-1:0]  iss_src1_tag_i, iss_src2_tag_i, iss_dst_tag_i;
  logic              cdb_valid_i;
  logic [TAG_W-1:0]  cdb_tag_i;
  logic [DATA_W-1:0] cdb_data_i;
  logic              res_valid_o;
  logic [TAG_W-1:0]  res_tag_o;
  logic [DATA_W-1:0] res_data_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rs_bank #(.N_ENT(N_ENT), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rs_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush_i        (flush_i),
    .rob_free_i     (rob_free_i),
    .iss_valid_i    (iss_valid_i),
    .iss_ready_o    (iss_ready_o),
    .iss_op_i       (iss_op_i),
    .iss_src1_rdy_i (iss_src1_rdy_i),
    .iss_src1_val_i (iss_src1_val_i),
    .iss_src1_tag_i (iss_src1_tag_i),
    .iss_src2_rdy_i (iss_src2_rdy_i),
    .iss_src2_val_i (iss_src2_val_i),
    .iss_src2_tag_i (iss_src2_tag_i),
    .iss_imm_i      (iss_imm_i),
    .iss_dst_tag_i  (iss_dst_tag_i),
    .cdb_valid_i    (cdb_valid_i),
    .cdb_tag_i      (cdb_tag_i),
    .cdb_data_i     (cdb_data_i),
    .res_valid_o    (res_valid_o),
    .res_tag_o      (res_tag_o),
    .res_data_o     (res_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    iss_valid_i    = 1'b0;
    iss_op_i       = '0;
    iss_src1_rdy_i = 1'b0;
    iss_src1_val_i = '0;
    iss_src1_tag_i = '0;
    iss_src2_rdy_i = 1'b0;
    iss_src2_val_i = '0;
    iss_src2_tag_i = '0;
    iss_imm_i      = '0;
    iss_dst_tag_i  = '0;
    cdb_valid_i    = 1'b0;
    cdb_tag_i      = '0;
    cdb_data_i     = '0;
  endtask

  task automatic put(input logic [2:0] op, input logic r1, input logic [15:0] v1,
                     input logic [3:0] t1, input logic r2, input logic [15:0] v2,
                     input logic [3:0] t2, input logic [15:0] imm, input logic [3:0] dst);
    iss_valid_i    = 1'b1;
    iss_op_i       = op;
    iss_src1_rdy_i = r1;
    iss_src1_val_i = v1;
    iss_src1_tag_i = t1;
    iss_src2_rdy_i = r2;
    iss_src2_val_i = v2;
    iss_src2_tag_i = t2;
    iss_imm_i      = imm;
    iss_dst_tag_i  = dst;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [15:0] data);
    cdb_valid_i = 1'b1;
    cdb_tag_i   = tag;
    cdb_data_i  = data;
  endtask

  task automatic t_reset();
    chk("R1 reset ready", 32'(iss_ready_o), 32'd1);
    chk("R7 reset no result", 32'(res_valid_o), 32'd0);
  endtask

  // R2 R7: all operand values given, result two edges after issue
  task automatic t_alu();
    logic [15:0] a [5];
    logic [15:0] b [5];
    logic [15:0] e [5];
    a[0] = 16'h1234; b[0] = 16'h0101; e[0] = 16'h1335;
    a[1] = 16'd50;   b[1] = 16'd8;    e[1] = 16'd42;
    a[2] = 16'hF0F0; b[2] = 16'h3C3C; e[2] = 16'h3030;
    a[3] = 16'hF0F0; b[3] = 16'h3C3C; e[3] = 16'hFCFC;
    a[4] = 16'hF0F0; b[4] = 16'h3C3C; e[4] = 16'hCCCC;
    for (int k = 0; k < 5; k++) begin
      put(3'(k), 1'b1, a[k], 4'd0, 1'b1, b[k], 4'd0, 16'd0, 4'(k + 1));
      step();
      idle();
      chk("R7 not early", 32'(res_valid_o), 32'd0);
      step();
      chk("R7 result valid", 32'(res_valid_o), 32'd1);
      chk("R7 result tag", 32'(res_tag_o), 32'(k + 1));
      chk("R2 result data", 32'(res_data_o), 32'(e[k]));
    end
    step();
  endtask

  // R3 R5: waiting operand, wrong tag ignored, matching tag captured
  task automatic t_pending();
    put(3'd0, 1'b1, 16'd10, 4'd0, 1'b0, 16'd0, 4'd9, 16'd0, 4'd3);
    step();
    idle();
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 waits for src2", 32'(res_valid_o), 32'd0);
    end
    bcast(4'd8, 16'd99);
    step();
    idle();
    step();
    chk("R3 other tag ignored", 32'(res_valid_o), 32'd0);
    bcast(4'd9, 16'd32);
    step();
    idle();
    chk("R3 capture edge", 32'(res_valid_o), 32'd0);
    step();
    chk("R3 result valid", 32'(res_valid_o), 32'd1);
    chk("R3 captured value", 32'(res_data_o), 32'd42);
    chk("R3 result tag", 32'(res_tag_o), 32'd3);
    step();
  endtask

  // R4: broadcast in the issue cycle
  task automatic t_forward();
    put(3'd1, 1'b0, 16'd0, 4'd2, 1'b1, 16'd5, 4'd0, 16'd0, 4'd12);
    bcast(4'd2, 16'd20);
    step();
    idle();
    step();
    chk("R4 forwarded valid", 32'(res_valid_o), 32'd1);
    chk("R4 forwarded data", 32'(res_data_o), 32'd15);
    chk("R4 forwarded tag", 32'(res_tag_o), 32'd12);
    step();
  endtask

  // R6: store goes on base alone
  task automatic t_store();
    put(3'd5, 1'b1, 16'd100, 4'd0, 1'b0, 16'd0, 4'd11, 16'd4, 4'd6);
    step();
    idle();
    step();
    chk("R6 store valid", 32'(res_valid_o), 32'd1);
    chk("R6 store address", 32'(res_data_o), 32'd104);
    chk("R6 store tag", 32'(res_tag_o), 32'd6);
    step();
  endtask

  // R1 R8 R10: fill, free one, rob stall, flush
  task automatic t_full_flush();
    for (int k = 0; k < N_ENT; k++) begin
      chk("R1 room before fill", 32'(iss_ready_o), 32'd1);
      put(3'd0, 1'b1, 16'(k + 1), 4'd0, 1'b0, 16'd0, 4'(8 + k), 16'd0, 4'(k + 1));
      step();
    end
    idle();
    chk("R1 full stalls", 32'(iss_ready_o), 32'd0);
    bcast(4'd9, 16'd5);
    step();
    idle();
    chk("R8 still full", 32'(iss_ready_o), 32'd0);
    step();
    chk("R8 result valid", 32'(res_valid_o), 32'd1);
    chk("R8 result tag", 32'(res_tag_o), 32'd2);
    chk("R8 result data", 32'(res_data_o), 32'd7);
    chk("R8 freed with result", 32'(iss_ready_o), 32'd1);
    rob_free_i = 1'b0;
    #1;
    chk("R1 rob full stalls", 32'(iss_ready_o), 32'd0);
    rob_free_i = 1'b1;
    flush_i = 1'b1;
    #1;
    chk("R1 flush blocks issue", 32'(iss_ready_o), 32'd0);
    step();
    flush_i = 1'b0;
    #1;
    chk("R10 empty after flush", 32'(iss_ready_o), 32'd1);
    chk("R10 no result", 32'(res_valid_o), 32'd0);
    bcast(4'd8, 16'd1);
    step();
    bcast(4'd10, 16'd1);
    step();
    chk("R10 flushed silent a", 32'(res_valid_o), 32'd0);
    bcast(4'd11, 16'd1);
    step();
    idle();
    chk("R10 flushed silent b", 32'(res_valid_o), 32'd0);
    step();
    chk("R10 flushed silent c", 32'(res_valid_o), 32'd0);
    step();
    chk("R10 flushed silent d", 32'(res_valid_o), 32'd0);
  endtask

  // R9 R11: older entry in higher station goes first, one per cycle
  task automatic t_oldest();
    put(3'd0, 1'b1, 16'd1, 4'd0, 1'b0, 16'd0, 4'd4, 16'd0, 4'd7);
    step();
    put(3'd0, 1'b1, 16'd2, 4'd0, 1'b0, 16'd0, 4'd6, 16'd0, 4'd8);
    step();
    idle();
    bcast(4'd4, 16'd10);
    step();
    idle();
    step();
    chk("R9 first entry out", 32'(res_tag_o), 32'd7);
    chk("R9 first entry data", 32'(res_data_o), 32'd11);
    put(3'd0, 1'b1, 16'd3, 4'd0, 1'b0, 16'd0, 4'd6, 16'd0, 4'd9);
    step();
    idle();
    bcast(4'd6, 16'd100);
    step();
    idle();
    step();
    chk("R9 oldest valid", 32'(res_valid_o), 32'd1);
    chk("R9 oldest first", 32'(res_tag_o), 32'd8);
    chk("R9 oldest data", 32'(res_data_o), 32'd102);
    step();
    chk("R11 second valid", 32'(res_valid_o), 32'd1);
    chk("R11 second next cycle", 32'(res_tag_o), 32'd9);
    chk("R11 second data", 32'(res_data_o), 32'd103);
    step();
    chk("R11 then idle", 32'(res_valid_o), 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    flush_i    = 1'b0;
    rob_free_i = 1'b1;
    idle();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_alu();
    t_pending();
    t_forward();
    t_store();
    t_full_flush();
    t_oldest();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule